// File: doc/BRIEF.md
# Banked GPIO Interrupt Detector

This block watches up to 118 general-purpose inputs and turns selected transitions or levels on them into a single interrupt request. The inputs are grouped into four banks. Bank 0 holds pins 0 to 31, bank 1 holds pins 32 to 53 (22 pins), bank 2 holds pins 54 to 85 and bank 3 holds pins 86 to 117. Each pin has its own trigger code and enable bit. Every pin passes through a two-flop synchroniser before it reaches the detectors.

Software talks to the block through a one-cycle command port. A command can set a pin's trigger code, set or clear one pin's enable, load a whole bank's enable mask, or clear one pin's pending bit. A separate read port returns one bank's 32-bit pending word together with the bank number, one cycle after the request. The interrupt output is asserted while any enabled pin is pending.

Top module: `gpio_irq_top`

## Requirements
- R1: An input change present at rising clock edge k reaches the pending word after edge k+2 and `irq_o` after edge k+3. `irq_o` is still low after edge k+2.
- R2: Trigger code 0 pends on a rising input, 1 on a falling input, 2 on either transition, 3 while the input is high and 4 while the input is low.
- R3: Trigger codes 5, 6 and 7 never set a pending bit, whatever the input does.
- R4: Commands are taken when `cfg_we` is high. `cfg_op` 0 writes `cfg_data[2:0]` as the trigger code of the addressed pin. `cfg_op` 1 writes `cfg_data[0]` as that pin's enable. `cfg_op` 2 replaces the enable bits of bank `cfg_bank` with `cfg_data`. `cfg_op` 3 clears the pending bit of the addressed pin.
- R5: A pin whose enable is 0 never latches an event. Clearing an enable also drops that pin's pending bit, and an edge seen while the pin was disabled is not remembered.
- R6: A pending bit stays set until a clear command for that pin. After a clear, an edge-triggered pin stays clear until its next qualifying edge.
- R7: A clear command wins over detection in the cycle it executes. A level-triggered pin whose level is still active reads 0 in the cycle after the clear and is pending again one cycle later.
- R8: `irq_o` is high exactly when, one cycle earlier, at least one enabled pin was pending.
- R9: A read request with `rd_bank` = b gives, after the next edge, `rd_valid_o` = 1, `rd_bank_o` = b and `rd_status_o` bit i = pending state of pin i of bank b.
- R10: Bank 1 has 22 pins. Its bits 22 to 31 always read 0, and enable or mask writes to those bits have no effect.
- R11: After reset every enable and pending bit is 0, `irq_o` is 0, and every trigger code is 0 (rising edge).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 118 | Asynchronous GPIO inputs, pin 0 at bit 0 |
| cfg_we | input | 1 | Command strobe, one command per cycle |
| cfg_op | input | 2 | Command: 0 trigger code, 1 pin enable, 2 bank mask, 3 clear pin |
| cfg_bank | input | 2 | Bank addressed by the command |
| cfg_pin | input | 5 | Pin within the bank addressed by the command |
| cfg_data | input | 32 | Command operand (code, enable bit or mask) |
| rd_req | input | 1 | Pending-word read request |
| rd_bank | input | 2 | Bank to read |
| rd_valid_o | output | 1 | Read result valid |
| rd_bank_o | output | 2 | Bank number of the read result |
| rd_status_o | output | 32 | Pending word of the bank read |
| irq_o | output | 1 | Interrupt request |

## Verification
Corrupted state in the block shows at the ports within one or two cycles. A pending bit set without its enable, or one that survives a clear, appears in the next pending-word read and holds `irq_o` high one edge later. A wrong trigger decode or a misplaced bank boundary shows up as a bit in the wrong place of the read word, or as a bit missing, a few cycles after the stimulus. The clear-versus-level race is checked on back-to-back reads, so a single-cycle error in its priority shows up.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    // Trigger codes held per pin.
    localparam logic [2:0] TRIG_RISE = 3'd0;
    localparam logic [2:0] TRIG_FALL = 3'd1;
    localparam logic [2:0] TRIG_BOTH = 3'd2;
    localparam logic [2:0] TRIG_HIGH = 3'd3;
    localparam logic [2:0] TRIG_LOW  = 3'd4;

    // Command codes on the configuration port.
    typedef enum logic [1:0] {
        OP_SET_TRIG  = 2'd0,
        OP_PIN_EN    = 2'd1,
        OP_BANK_MASK = 2'd2,
        OP_CLEAR     = 2'd3
    } cfg_op_e;

    // Number of pins actually present in bank b.
    function automatic int bank_width(int b, int bank_w, int narrow_bank, int narrow_pins);
        return (b == narrow_bank) ? narrow_pins : bank_w;
    endfunction

    // Event decode for one pin; reserved codes yield no event.
    function automatic logic trig_hit(logic [2:0] code, logic lvl, logic prev);
        logic hit;
        case (code)
            TRIG_RISE: hit = lvl & ~prev;
            TRIG_FALL: hit = ~lvl & prev;
            TRIG_BOTH: hit = lvl ^ prev;
            TRIG_HIGH: hit = lvl;
            TRIG_LOW:  hit = ~lvl;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] prev_o
);

    typedef struct packed {
        logic [W-1:0] meta;
        logic [W-1:0] lvl;
        logic [W-1:0] prev;
    } sync_s;

    sync_s sync_d, sync_q;

    always_comb begin
        sync_d      = sync_q;
        sync_d.meta = d_i;
        sync_d.lvl  = sync_q.meta;
        sync_d.prev = sync_q.lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '0;
        end else begin
            sync_q <= sync_d;
        end
    end

    assign lvl_o  = sync_q.lvl;
    assign prev_o = sync_q.prev;

endmodule

// File: rtl/gpio_irq_event.sv
module gpio_irq_event
    import gpio_irq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0][2:0] typ_i,
    input  logic [W-1:0]      lvl_i,
    input  logic [W-1:0]      prev_i,
    output logic [W-1:0]      evt_o
);

    for (genvar i = 0; i < W; i++) begin : g_pin
        assign evt_o[i] = trig_hit(typ_i[i], lvl_i[i], prev_i[i]);
    end

endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_irq_pkg::*;
#(
    parameter int BANK_W    = 32,
    parameter int PINS      = 32,
    parameter int BANK_IDX  = 0,
    parameter int BANK_BITS = 2,
    parameter int PIN_BITS  = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_op,
    input  logic [BANK_BITS-1:0] cfg_bank,
    input  logic [PIN_BITS-1:0]  cfg_pin,
    input  logic [BANK_W-1:0]    cfg_data,
    input  logic [BANK_W-1:0]    lvl_i,
    input  logic [BANK_W-1:0]    prev_i,
    output logic [BANK_W-1:0]    pend_o,
    output logic [BANK_W-1:0]    en_o
);

    localparam logic [BANK_W-1:0] VALID_MASK = {BANK_W{1'b1}} >> (BANK_W - PINS);

    typedef struct packed {
        logic [BANK_W-1:0][2:0] typ;
        logic [BANK_W-1:0]      en;
        logic [BANK_W-1:0]      pend;
    } bank_s;

    bank_s bank_d, bank_q;

    logic [BANK_W-1:0] evt;
    logic [BANK_W-1:0] clr_vec;
    logic              hit;
    logic              pin_ok;

    gpio_irq_event #(
        .W(BANK_W)
    ) u_event (
        .typ_i (bank_q.typ),
        .lvl_i (lvl_i),
        .prev_i(prev_i),
        .evt_o (evt)
    );

    always_comb begin
        bank_d  = bank_q;
        clr_vec = '0;
        hit     = cfg_we && (int'(cfg_bank) == BANK_IDX);
        pin_ok  = int'(cfg_pin) < PINS;
        if (hit) begin
            case (cfg_op_e'(cfg_op))
                OP_SET_TRIG: begin
                    if (pin_ok) bank_d.typ[cfg_pin] = cfg_data[2:0];
                end
                OP_PIN_EN: begin
                    if (pin_ok) bank_d.en[cfg_pin] = cfg_data[0];
                end
                OP_BANK_MASK: begin
                    bank_d.en = cfg_data & VALID_MASK;
                end
                OP_CLEAR: begin
                    if (pin_ok) clr_vec[cfg_pin] = 1'b1;
                end
                default: begin
                end
            endcase
        end
        // Clear wins this cycle; new events only latch on enabled pins.
        bank_d.pend = (bank_q.pend | evt) & bank_d.en & ~clr_vec & VALID_MASK;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bank_q <= '0;
        end else begin
            bank_q <= bank_d;
        end
    end

    assign pend_o = bank_q.pend;
    assign en_o   = bank_q.en;

endmodule

// File: rtl/gpio_irq_top.sv
module gpio_irq_top
    import gpio_irq_pkg::*;
#(
    parameter  int NUM_BANKS   = 4,
    parameter  int BANK_W      = 32,
    parameter  int NARROW_BANK = 1,
    parameter  int NARROW_PINS = 22,
    localparam int BANK_BITS   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
    localparam int PIN_BITS    = (BANK_W > 1) ? $clog2(BANK_W) : 1,
    localparam int NUM_PINS    = NUM_BANKS * BANK_W - (BANK_W - NARROW_PINS)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_PINS-1:0]  pin_i,
    input  logic                 cfg_we,
    input  logic [1:0]           cfg_op,
    input  logic [BANK_BITS-1:0] cfg_bank,
    input  logic [PIN_BITS-1:0]  cfg_pin,
    input  logic [BANK_W-1:0]    cfg_data,
    input  logic                 rd_req,
    input  logic [BANK_BITS-1:0] rd_bank,
    output logic                 rd_valid_o,
    output logic [BANK_BITS-1:0] rd_bank_o,
    output logic [BANK_W-1:0]    rd_status_o,
    output logic                 irq_o
);

    function automatic int bank_base(int b);
        int s = 0;
        for (int k = 0; k < b; k++) begin
            s += bank_width(k, BANK_W, NARROW_BANK, NARROW_PINS);
        end
        return s;
    endfunction

    typedef struct packed {
        logic                 irq;
        logic                 rd_valid;
        logic [BANK_BITS-1:0] rd_bank;
        logic [BANK_W-1:0]    rd_status;
    } top_s;

    top_s top_d, top_q;

    logic [NUM_PINS-1:0]               lvl;
    logic [NUM_PINS-1:0]               prev;
    logic [NUM_BANKS-1:0][BANK_W-1:0]  pend_all;
    logic [NUM_BANKS-1:0][BANK_W-1:0]  en_all;

    gpio_irq_sync #(
        .W(NUM_PINS)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (pin_i),
        .lvl_o (lvl),
        .prev_o(prev)
    );

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam int PINS = bank_width(g, BANK_W, NARROW_BANK, NARROW_PINS);
        localparam int BASE = bank_base(g);

        logic [BANK_W-1:0] b_lvl;
        logic [BANK_W-1:0] b_prev;

        always_comb begin
            b_lvl              = '0;
            b_prev             = '0;
            b_lvl[PINS-1:0]    = lvl[BASE +: PINS];
            b_prev[PINS-1:0]   = prev[BASE +: PINS];
        end

        gpio_irq_bank #(
            .BANK_W   (BANK_W),
            .PINS     (PINS),
            .BANK_IDX (g),
            .BANK_BITS(BANK_BITS),
            .PIN_BITS (PIN_BITS)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_we  (cfg_we),
            .cfg_op  (cfg_op),
            .cfg_bank(cfg_bank),
            .cfg_pin (cfg_pin),
            .cfg_data(cfg_data),
            .lvl_i   (b_lvl),
            .prev_i  (b_prev),
            .pend_o  (pend_all[g]),
            .en_o    (en_all[g])
        );
    end

    always_comb begin
        top_d          = top_q;
        top_d.irq      = |(pend_all & en_all);
        top_d.rd_valid = rd_req;
        if (rd_req) begin
            top_d.rd_bank   = rd_bank;
            top_d.rd_status = (int'(rd_bank) < NUM_BANKS) ? pend_all[rd_bank] : '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign irq_o       = top_q.irq;
    assign rd_valid_o  = top_q.rd_valid;
    assign rd_bank_o   = top_q.rd_bank;
    assign rd_status_o = top_q.rd_status;

endmodule

// File: rtl/gpio_irq_chk.sv
module gpio_irq_chk
    import gpio_irq_pkg::*;
#(
    parameter int NUM_BANKS   = 4,
    parameter int BANK_W      = 32,
    parameter int NARROW_BANK = 1,
    parameter int NARROW_PINS = 22,
    parameter int BANK_BITS   = 2,
    parameter int PIN_BITS    = 5
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              cfg_we,
    input logic [1:0]                        cfg_op,
    input logic [BANK_BITS-1:0]              cfg_bank,
    input logic [PIN_BITS-1:0]               cfg_pin,
    input logic                              rd_req,
    input logic [BANK_BITS-1:0]              rd_bank,
    input logic                              rd_valid_o,
    input logic [BANK_BITS-1:0]              rd_bank_o,
    input logic                              irq_o,
    input logic [NUM_BANKS-1:0][BANK_W-1:0]  pend_all,
    input logic [NUM_BANKS-1:0][BANK_W-1:0]  en_all
);

    localparam logic [BANK_W-1:0] NARROW_VALID = {BANK_W{1'b1}} >> (BANK_W - NARROW_PINS);

    // R5: nothing is pending on a disabled pin
    a_r5_pend_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_all & ~en_all) == '0);

    // R10: bits above the narrow bank's pins stay zero
    a_r10_narrow_unused: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend_all[NARROW_BANK] | en_all[NARROW_BANK]) & ~NARROW_VALID) == '0);

    // R8: interrupt follows the enabled pending bits by one cycle
    a_r8_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(|(pend_all & en_all)));

    // R9: read response valid one cycle after the request
    a_r9_rd_valid: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid_o == $past(rd_req));

    // R9: response carries the requested bank number
    a_r9_rd_bank: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> rd_bank_o == $past(rd_bank));

    // R7: the addressed pin is clear right after a clear command
    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_op == OP_CLEAR && int'(cfg_bank) < NUM_BANKS)
        |=> pend_all[$past(cfg_bank)][$past(cfg_pin)] == 1'b0);

endmodule

bind gpio_irq_top gpio_irq_chk #(
    .NUM_BANKS  (NUM_BANKS),
    .BANK_W     (BANK_W),
    .NARROW_BANK(NARROW_BANK),
    .NARROW_PINS(NARROW_PINS),
    .BANK_BITS  (BANK_BITS),
    .PIN_BITS   (PIN_BITS)
) u_gpio_irq_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_op    (cfg_op),
    .cfg_bank  (cfg_bank),
    .cfg_pin   (cfg_pin),
    .rd_req    (rd_req),
    .rd_bank   (rd_bank),
    .rd_valid_o(rd_valid_o),
    .rd_bank_o (rd_bank_o),
    .irq_o     (irq_o),
    .pend_all  (pend_all),
    .en_all    (en_all)
);

// File: tb/test_gpio_irq_top.sv
`timescale 1ns/1ps
module test_gpio_irq_top;

    localparam int NP = 118;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pins = '0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_op = '0;
    logic [1:0]    cfg_bank = '0;
    logic [4:0]    cfg_pin = '0;
    logic [31:0]   cfg_data = '0;
    logic          rd_req = 1'b0;
    logic [1:0]    rd_bank = '0;
    logic          rd_valid_o;
    logic [1:0]    rd_bank_o;
    logic [31:0]   rd_status_o;
    logic          irq_o;

    int n_checks = 0;
    int n_err = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    gpio_irq_top i_gpio_irq_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (pins),
        .cfg_we     (cfg_we),
        .cfg_op     (cfg_op),
        .cfg_bank   (cfg_bank),
        .cfg_pin    (cfg_pin),
        .cfg_data   (cfg_data),
        .rd_req     (rd_req),
        .rd_bank    (rd_bank),
        .rd_valid_o (rd_valid_o),
        .rd_bank_o  (rd_bank_o),
        .rd_status_o(rd_status_o),
        .irq_o      (irq_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // All tasks are entered and left at a falling edge.
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cmd(input logic [1:0] op, input logic [1:0] bank,
                       input logic [4:0] pin, input logic [31:0] data);
        cfg_we = 1'b1; cfg_op = op; cfg_bank = bank; cfg_pin = pin; cfg_data = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic read_bank(input logic [1:0] bank, output logic [31:0] st);
        rd_req = 1'b1; rd_bank = bank;
        @(negedge clk);
        rd_req = 1'b0;
        st = rd_status_o;
        check("R9", "rd_valid", 32'(rd_valid_o), 32'd1);
        check("R9", "rd_bank", 32'(rd_bank_o), 32'(bank));
    endtask

    task automatic t_reset();
        logic [31:0] st;
        check("R11", "irq after reset", 32'(irq_o), 32'd0);
        for (int b = 0; b < 4; b++) begin
            read_bank(2'(b), st);
            check("R11", "status after reset", st, 32'd0);
        end
        // default code is rising edge
        cmd(2'd1, 2'd0, 5'd1, 32'd1);
        pins[1] = 1'b1; idle(4);
        read_bank(2'd0, st);
        check("R11", "default rising code", st, 32'h2);
        cmd(2'd3, 2'd0, 5'd1, 32'd0);
        cmd(2'd1, 2'd0, 5'd1, 32'd0);
        pins[1] = 1'b0; idle(4);
    endtask

    task automatic t_rising();
        logic [31:0] st;
        cmd(2'd0, 2'd0, 5'd3, 32'd0);
        cmd(2'd1, 2'd0, 5'd3, 32'd1);
        pins[3] = 1'b1;
        idle(3);
        check("R1", "irq still low after k+2", 32'(irq_o), 32'd0);
        read_bank(2'd0, st);
        check("R1", "pending after k+2", st, 32'h8);
        check("R1", "irq high after k+3", 32'(irq_o), 32'd1);
        cmd(2'd3, 2'd0, 5'd3, 32'd0);
        idle(2);
        read_bank(2'd0, st);
        check("R6", "edge pin stays clear", st, 32'd0);
        check("R8", "irq low with nothing pending", 32'(irq_o), 32'd0);
        pins[3] = 1'b0; idle(4);
        read_bank(2'd0, st);
        check("R2", "rising ignores fall", st, 32'd0);
        cmd(2'd1, 2'd0, 5'd3, 32'd0);
    endtask

    task automatic t_falling();
        logic [31:0] st;
        cmd(2'd0, 2'd2, 5'd5, 32'd1);
        cmd(2'd1, 2'd2, 5'd5, 32'd1);
        pins[59] = 1'b1; idle(4);
        read_bank(2'd2, st);
        check("R2", "falling ignores rise", st, 32'd0);
        pins[59] = 1'b0; idle(4);
        read_bank(2'd2, st);
        check("R2", "falling detected", st, 32'h20);
        check("R8", "irq high with bank 2 pending", 32'(irq_o), 32'd1);
        cmd(2'd3, 2'd2, 5'd5, 32'd0);
        cmd(2'd1, 2'd2, 5'd5, 32'd0);
    endtask

    task automatic t_both();
        logic [31:0] st;
        cmd(2'd0, 2'd3, 5'd31, 32'd2);
        cmd(2'd1, 2'd3, 5'd31, 32'd1);
        pins[117] = 1'b1; idle(4);
        read_bank(2'd3, st);
        check("R2", "both: rise", st, 32'h8000_0000);
        cmd(2'd3, 2'd3, 5'd31, 32'd0);
        idle(1);
        read_bank(2'd3, st);
        check("R6", "both: cleared", st, 32'd0);
        pins[117] = 1'b0; idle(4);
        read_bank(2'd3, st);
        check("R2", "both: fall", st, 32'h8000_0000);
        cmd(2'd3, 2'd3, 5'd31, 32'd0);
        cmd(2'd1, 2'd3, 5'd31, 32'd0);
    endtask

    task automatic t_level_high();
        logic [31:0] st;
        cmd(2'd0, 2'd0, 5'd10, 32'd3);
        cmd(2'd1, 2'd0, 5'd10, 32'd1);
        pins[10] = 1'b1; idle(4);
        read_bank(2'd0, st);
        check("R2", "high level pending", st, 32'h400);
        cmd(2'd3, 2'd0, 5'd10, 32'd0);
        read_bank(2'd0, st);
        check("R7", "level reads 0 right after clear", st, 32'd0);
        read_bank(2'd0, st);
        check("R7", "level pending again", st, 32'h400);
        cmd(2'd1, 2'd0, 5'd10, 32'd0);
        idle(2);
        read_bank(2'd0, st);
        check("R5", "disable drops pending", st, 32'd0);
        check("R5", "irq low after disable", 32'(irq_o), 32'd0);
        pins[10] = 1'b0; idle(2);
    endtask

    task automatic t_level_low();
        logic [31:0] st;
        cmd(2'd0, 2'd1, 5'd0, 32'd4);
        cmd(2'd1, 2'd1, 5'd0, 32'd1);
        idle(2);
        read_bank(2'd1, st);
        check("R2", "low level pending", st, 32'h1);
        pins[32] = 1'b1; idle(4);
        read_bank(2'd1, st);
        check("R6", "pending held after level leaves", st, 32'h1);
        cmd(2'd3, 2'd1, 5'd0, 32'd0);
        idle(1);
        read_bank(2'd1, st);
        check("R6", "cleared with level inactive", st, 32'd0);
        cmd(2'd1, 2'd1, 5'd0, 32'd0);
        pins[32] = 1'b0; idle(2);
    endtask

    task automatic t_bad_code();
        logic [31:0] st;
        cmd(2'd0, 2'd2, 5'd7, 32'd5);
        cmd(2'd1, 2'd2, 5'd7, 32'd1);
        pins[61] = 1'b1; idle(4);
        pins[61] = 1'b0; idle(4);
        read_bank(2'd2, st);
        check("R3", "code 5 no event", st, 32'd0);
        cmd(2'd0, 2'd2, 5'd7, 32'd7);
        idle(4);
        read_bank(2'd2, st);
        check("R3", "code 7 no event", st, 32'd0);
        check("R3", "irq low with reserved code", 32'(irq_o), 32'd0);
        cmd(2'd1, 2'd2, 5'd7, 32'd0);
    endtask

    task automatic t_mask();
        logic [31:0] st;
        cmd(2'd2, 2'd1, 5'd0, 32'hFFFF_FFFF);
        for (int i = 32; i < 54; i++) pins[i] = 1'b1;
        idle(4);
        read_bank(2'd1, st);
        check("R4", "bank mask enables all pins", st, 32'h003F_FFFF);
        check("R10", "bank 1 upper bits zero", st & 32'hFFC0_0000, 32'd0);
        check("R8", "irq from bank 1", 32'(irq_o), 32'd1);
        cmd(2'd2, 2'd1, 5'd0, 32'd0);
        idle(2);
        read_bank(2'd1, st);
        check("R5", "mask clear drops pending", st, 32'd0);
        check("R8", "irq low after mask clear", 32'(irq_o), 32'd0);
        for (int i = 32; i < 54; i++) pins[i] = 1'b0;
        idle(4);
        for (int i = 32; i < 54; i++) pins[i] = 1'b1;
        idle(4);
        cmd(2'd2, 2'd1, 5'd0, 32'h003F_FFFF);
        idle(4);
        read_bank(2'd1, st);
        check("R5", "edge while disabled not kept", st, 32'd0);
        cmd(2'd2, 2'd1, 5'd0, 32'd0);
        cmd(2'd0, 2'd1, 5'd25, 32'd3);
        cmd(2'd1, 2'd1, 5'd25, 32'd1);
        idle(4);
        read_bank(2'd1, st);
        check("R10", "pin write beyond bank 1 ignored", st, 32'd0);
        check("R10", "irq low for absent pin", 32'(irq_o), 32'd0);
        for (int i = 32; i < 54; i++) pins[i] = 1'b0;
        idle(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_rising();
        t_falling();
        t_both();
        t_level_high();
        t_mask();
        t_level_low();
        t_bad_code();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule